// File: doc/BRIEF.md
# Iterative Shift-and-Add Vector Rotator

This block evaluates trigonometric quantities with the CORDIC method. It uses a single datapath and runs one micro-rotation per clock. Three signed registers are involved: two hold the vector components and a third holds the angle still to be applied. A pulse on the load input copies the three operands into these registers and restarts the step counter. The block then performs a fixed number of steps and raises a one-cycle completion flag. Each step shifts the two components right by the step index, adds or subtracts them, and adds or removes one elementary angle from a small constant table.

The mode bit is sampled at load. In rotation mode the vector is turned by the angle operand, so a load of (A, 0, θ) gives A·K·cos θ and A·K·sin θ. In vectoring mode the vector is turned onto the positive x axis, so the result is K times its length, and the accumulated angle is its arctangent. The gain K ≈ 1.64676 is not removed. It remains in both component outputs, and downstream logic scales it out when it needs to.

Angles use a binary scale: the signed word range covers −π to +π, so π/4 is 2^(WIDTH−3). Angle operands must stay within ±π/2. Vectoring needs x ≥ 0. Component operands must stay within ±2^(WIDTH−3) so that the gain cannot overflow the word.

Top module: `cordic_iter`

## Requirements
- R1: While rst_ni is low and after its release, done_o is 0 and x_o, y_o and z_o are 0 until the first load.
- R2: On the clock edge where load_i is 1, x_o, y_o and z_o take x_i, y_i and z_i, and done_o is 0 in the cycle that follows.
- R3: done_o is 1 for exactly one cycle. That cycle follows the ITER-th rising edge after the load edge.
- R4: In rotation mode (mode_i = 0), step k with z ≥ 0 does x −= y>>>k, y += x>>>k, z −= angle(k). With z < 0, every sign is reversed.
- R5: In vectoring mode (mode_i = 1), step k with y < 0 does x −= y>>>k, y += x>>>k, z −= angle(k). With y ≥ 0, every sign is reversed.
- R6: angle(k) equals round(atan(2^−k)·2^(WIDTH−1)/π). For WIDTH = 16 this gives angle(0) = 8192 and angle(1) = 4836.
- R7: In rotation mode, loading (A, 0, θ) ends with x_o ≈ K·A·cos θ and y_o ≈ K·A·sin θ, where K ≈ 1.64676, within 8 LSB.
- R8: In vectoring mode, loading (x, y, 0) with x > 0 ends with x_o ≈ K·√(x²+y²) and z_o ≈ atan2(y, x) in the angle scale, within 8 LSB.
- R9: A load during a run discards that run. No done_o pulse belongs to it, and the new run completes ITER edges after the new load.
- R10: Between a completed run and the next load, x_o, y_o, z_o do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture operands and start a run |
| mode_i | input | 1 | 0 = rotation, 1 = vectoring; sampled at load |
| x_i | input | WIDTH | Initial x component, signed |
| y_i | input | WIDTH | Initial y component, signed |
| z_i | input | WIDTH | Initial angle, signed, ±π full scale |
| x_o | output | WIDTH | Current/final x component |
| y_o | output | WIDTH | Current/final y component |
| z_o | output | WIDTH | Current/final residual or accumulated angle |
| done_o | output | 1 | One-cycle flag: results final |

## Verification
The bench goes after the step-direction rule where the steering value is exactly zero. If zero is treated as negative, rotation by a zero angle yields a residual of +8192 after the first step instead of −8192. The bench also covers the last table entries, which round to 0 or 1: a table with truncation instead of rounding drifts the angle by a few LSB. Completion timing is probed with an immediate reload in the middle of a run. An off-by-one counter moves the done pulse, and a counter that is not cleared on load emits a pulse for the aborted run. The idle hold after completion is checked too, because a datapath that keeps stepping past the last index would corrupt the results that downstream logic reads late.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

   typedef enum logic {
      CORDIC_ROTATE = 1'b0,
      CORDIC_VECTOR = 1'b1
   } cordic_mode_e;

   // Fixed-point arithmetic in Q30: atan(2^-k) by its power series,
   // then rescaled so that pi corresponds to 2^(w-1).
   function automatic longint atan_code(input int k, input int w);
      longint one_q;
      longint t_q;
      longint t2_q;
      longint pw_q;
      longint acc_q;
      longint term_q;
      longint pi_q;
      one_q = longint'(1) <<< 30;
      pi_q  = 64'sd3373259426;
      if (k == 0) begin
         return longint'(1) <<< (w - 3);
      end
      t_q   = one_q >>> k;
      t2_q  = (t_q * t_q) >>> 30;
      pw_q  = t_q;
      acc_q = 0;
      for (int n = 0; n < 40; n++) begin
         term_q = pw_q / longint'(2 * n + 1);
         if ((n % 2) == 1) acc_q = acc_q - term_q;
         else              acc_q = acc_q + term_q;
         pw_q = (pw_q * t2_q) >>> 30;
      end
      return (acc_q * (longint'(1) <<< (w - 1)) + (pi_q / 2)) / pi_q;
   endfunction

endpackage

// File: rtl/cordic_angle_rom.sv
module cordic_angle_rom #(
   parameter int WIDTH = 16,
   parameter int ITER  = 16,
   localparam int IDXW = (ITER > 1) ? $clog2(ITER) : 1
) (
   input  logic [IDXW-1:0]   idx_i,
   output logic [WIDTH-1:0]  angle_o
);

   logic [WIDTH-1:0] table_w [ITER];

   for (genvar k = 0; k < ITER; k++) begin : g_entry
      localparam longint CODE = cordic_pkg::atan_code(k, WIDTH);
      assign table_w[k] = WIDTH'(CODE);
   end

   always_comb begin
      angle_o = '0;
      for (int k = 0; k < ITER; k++) begin
         if (idx_i == IDXW'(k)) angle_o = table_w[k];
      end
   end

endmodule

// File: rtl/cordic_step.sv
module cordic_step #(
   parameter int WIDTH = 16,
   parameter int ITER  = 16,
   localparam int IDXW = (ITER > 1) ? $clog2(ITER) : 1
) (
   input  logic signed [WIDTH-1:0] x_i,
   input  logic signed [WIDTH-1:0] y_i,
   input  logic signed [WIDTH-1:0] z_i,
   input  logic [IDXW-1:0]         idx_i,
   input  cordic_pkg::cordic_mode_e mode_i,
   input  logic signed [WIDTH-1:0] angle_i,
   output logic signed [WIDTH-1:0] x_o,
   output logic signed [WIDTH-1:0] y_o,
   output logic signed [WIDTH-1:0] z_o
);

   logic signed [WIDTH-1:0] x_sh;
   logic signed [WIDTH-1:0] y_sh;
   logic                    pos_step;

   assign x_sh = x_i >>> idx_i;
   assign y_sh = y_i >>> idx_i;

   // rotation steers on the residual angle, vectoring on the y component
   always_comb begin
      if (mode_i == cordic_pkg::CORDIC_ROTATE) pos_step = ~z_i[WIDTH-1];
      else                                     pos_step =  y_i[WIDTH-1];
   end

   always_comb begin
      if (pos_step) begin
         x_o = x_i - y_sh;
         y_o = y_i + x_sh;
         z_o = z_i - angle_i;
      end else begin
         x_o = x_i + y_sh;
         y_o = y_i - x_sh;
         z_o = z_i + angle_i;
      end
   end

endmodule

// File: rtl/cordic_seq.sv
module cordic_seq #(
   parameter int ITER = 16,
   localparam int IDXW = (ITER > 1) ? $clog2(ITER) : 1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            load_i,
   output logic            busy_o,
   output logic            done_o,
   output logic [IDXW-1:0] idx_o
);

   localparam logic [IDXW-1:0] LAST = IDXW'(ITER - 1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_o <= 1'b0;
         done_o <= 1'b0;
         idx_o  <= '0;
      end else if (load_i) begin
         busy_o <= 1'b1;
         done_o <= 1'b0;
         idx_o  <= '0;
      end else if (busy_o) begin
         done_o <= (idx_o == LAST);
         if (idx_o == LAST) busy_o <= 1'b0;
         else               idx_o  <= idx_o + 1'b1;
      end else begin
         done_o <= 1'b0;
      end
   end

endmodule

// File: rtl/cordic_iter.sv
module cordic_iter #(
   parameter int WIDTH = 16,
   parameter int ITER  = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic             mode_i,
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   input  logic [WIDTH-1:0] z_i,
   output logic [WIDTH-1:0] x_o,
   output logic [WIDTH-1:0] y_o,
   output logic [WIDTH-1:0] z_o,
   output logic             done_o
);

   localparam int IDXW = (ITER > 1) ? $clog2(ITER) : 1;

   initial begin
      assert (WIDTH >= 6 && WIDTH <= 30)
         else $error("cordic_iter: WIDTH out of supported range");
      assert (ITER >= 1 && ITER <= WIDTH)
         else $error("cordic_iter: ITER must lie in 1..WIDTH");
   end

   logic                     busy_w;
   logic [IDXW-1:0]          idx_w;
   logic [WIDTH-1:0]         angle_w;
   cordic_pkg::cordic_mode_e mode_q;
   logic signed [WIDTH-1:0]  x_q, y_q, z_q;
   logic signed [WIDTH-1:0]  x_n, y_n, z_n;

   cordic_seq #(.ITER(ITER)) u_seq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load_i),
      .busy_o (busy_w),
      .done_o (done_o),
      .idx_o  (idx_w)
   );

   cordic_angle_rom #(.WIDTH(WIDTH), .ITER(ITER)) u_rom (
      .idx_i   (idx_w),
      .angle_o (angle_w)
   );

   cordic_step #(.WIDTH(WIDTH), .ITER(ITER)) u_step (
      .x_i     (x_q),
      .y_i     (y_q),
      .z_i     (z_q),
      .idx_i   (idx_w),
      .mode_i  (mode_q),
      .angle_i (angle_w),
      .x_o     (x_n),
      .y_o     (y_n),
      .z_o     (z_n)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         x_q    <= '0;
         y_q    <= '0;
         z_q    <= '0;
         mode_q <= cordic_pkg::CORDIC_ROTATE;
      end else if (load_i) begin
         x_q    <= x_i;
         y_q    <= y_i;
         z_q    <= z_i;
         mode_q <= cordic_pkg::cordic_mode_e'(mode_i);
      end else if (busy_w) begin
         x_q <= x_n;
         y_q <= y_n;
         z_q <= z_n;
      end
   end

   assign x_o = x_q;
   assign y_o = y_q;
   assign z_o = z_q;

endmodule

// File: rtl/cordic_iter_chk.sv
module cordic_iter_chk #(
   parameter int WIDTH = 16,
   parameter int ITER  = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             load_i,
   input logic             mode_i,
   input logic [WIDTH-1:0] x_i,
   input logic [WIDTH-1:0] y_i,
   input logic [WIDTH-1:0] z_i,
   input logic [WIDTH-1:0] x_o,
   input logic [WIDTH-1:0] y_o,
   input logic [WIDTH-1:0] z_o,
   input logic             done_o
);

   localparam int CW = $clog2(ITER + 1);

   logic          run_q;
   logic          vec_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q <= 1'b0;
         vec_q <= 1'b0;
         cnt_q <= '0;
      end else if (load_i) begin
         run_q <= 1'b1;
         vec_q <= mode_i;
         cnt_q <= '0;
      end else if (run_q) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == CW'(ITER - 1)) run_q <= 1'b0;
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R3
   AST_DONE_TIMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (!run_q && cnt_q == CW'(ITER))); // R3
   AST_NO_DONE_RUNNING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q |-> !done_o); // R9
   AST_LOAD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (x_o == $past(x_i) && y_o == $past(y_i) && z_o == $past(z_i) && !done_o)); // R2
   AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_q && !load_i) |=> ($stable(x_o) && $stable(y_o) && $stable(z_o))); // R10
   AST_ROT_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && !vec_q && !load_i && !z_o[WIDTH-1]) |=> ($signed(z_o) <= $signed($past(z_o)))); // R4
   AST_VEC_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && vec_q && !load_i && !y_o[WIDTH-1]) |=> ($signed(z_o) >= $signed($past(z_o)))); // R5

endmodule

bind cordic_iter cordic_iter_chk #(.WIDTH(WIDTH), .ITER(ITER)) u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .load_i (load_i),
   .mode_i (mode_i),
   .x_i    (x_i),
   .y_i    (y_i),
   .z_i    (z_i),
   .x_o    (x_o),
   .y_o    (y_o),
   .z_o    (z_o),
   .done_o (done_o)
);

// File: tb/cordic_iter_tb_top.sv
module cordic_iter_tb_top;

   localparam int W = 16;
   localparam int N = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic load = 1'b0;
   logic mode = 1'b0;
   logic signed [W-1:0] xi = '0, yi = '0, zi = '0;
   logic signed [W-1:0] xo, yo, zo;
   logic done;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   cordic_iter #(.WIDTH(W), .ITER(N)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .load_i(load), .mode_i(mode),
      .x_i(xi), .y_i(yi), .z_i(zi),
      .x_o(xo), .y_o(yo), .z_o(zo), .done_o(done)
   );

   // reference angle table from the requirement formula
   int tab [N];
   real pi_r;
   initial begin
      pi_r = 4.0 * $atan(1.0);
      for (int k = 0; k < N; k++)
         tab[k] = $rtoi($atan(1.0 / (2.0 ** k)) * (2.0 ** (W - 1)) / pi_r + 0.5);
   end

   // behavioural reference model, advanced on every rising edge
   int mx = 0, my = 0, mz = 0, mk = 0;
   bit mbusy = 0, mdone = 0, mvec = 0;

   always @(posedge clk or negedge rst_n) begin
      int xs, ys;
      bit up;
      if (!rst_n) begin
         mx = 0; my = 0; mz = 0; mk = 0; mbusy = 0; mdone = 0; mvec = 0;
      end else begin
         mdone = 0;
         if (load) begin
            mx = int'(xi); my = int'(yi); mz = int'(zi);
            mk = 0; mbusy = 1; mvec = mode;
         end else if (mbusy) begin
            xs = mx >>> mk;
            ys = my >>> mk;
            up = mvec ? (my < 0) : (mz >= 0);
            if (up) begin
               mx = mx - ys; my = my + xs; mz = mz - tab[mk];
            end else begin
               mx = mx + ys; my = my - xs; mz = mz + tab[mk];
            end
            mk++;
            if (mk == N) begin
               mbusy = 0; mdone = 1;
            end
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // compare against the model on every cycle, away from the edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         string tag;
         tag = mbusy ? (mvec ? "R5" : "R4") : "R10";
         check(int'(done) == int'(mdone), "R3", "done_o", int'(done), int'(mdone));
         check(int'(xo) == mx, tag, "x_o", int'(xo), mx);
         check(int'(yo) == my, tag, "y_o", int'(yo), my);
         check(int'(zo) == mz, tag, "z_o", int'(zo), mz);
      end
   end

   task automatic start(input bit m, input int x, input int y, input int z);
      @(negedge clk);
      load = 1'b1; mode = m; xi = W'(x); yi = W'(y); zi = W'(z);
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic run_full(input bit m, input int x, input int y, input int z);
      start(m, x, y, z);
      check(xo == W'(x) && yo == W'(y) && zo == W'(z), "R2", "captured x_o", int'(xo), x);
      check(done == 1'b0, "R2", "done after load", int'(done), 0);
      for (int i = 1; i < N; i++) begin
         @(negedge clk);
         check(done == 1'b0, "R3", "early done", int'(done), 0);
      end
      @(negedge clk);
      check(done == 1'b1, "R3", "done at step count", int'(done), 1);
   endtask

   function automatic int iabs(input int v);
      return (v < 0) ? -v : v;
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      real kg;
      int ex, ey, ez, xsave, ysave, zsave;
      kg = 1.64676;
      repeat (3) @(negedge clk);
      check(done == 1'b0 && xo == 0 && yo == 0 && zo == 0, "R1", "outputs in reset", int'(xo), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(done == 1'b0 && xo == 0 && zo == 0, "R1", "outputs after reset", int'(zo), 0);

      // R6: zero residual steers positive; first two angles observed on z
      start(1'b0, 0, 0, 0);
      @(negedge clk);
      check(int'(zo) == -8192, "R6", "z after step 0", int'(zo), -8192);
      check(int'(zo) != 8192, "R4", "zero z treated as positive", int'(zo), -8192);
      @(negedge clk);
      check(int'(zo) == -8192 + 4836, "R6", "z after step 1", int'(zo), -8192 + 4836);
      repeat (N) @(negedge clk);

      // R7: rotation by +30 degrees
      run_full(1'b0, 8000, 0, 5461);
      ex = $rtoi(kg * 8000.0 * $cos(pi_r / 6.0));
      ey = $rtoi(kg * 8000.0 * $sin(pi_r / 6.0));
      check(iabs(int'(xo) - ex) <= 8, "R7", "K*A*cos", int'(xo), ex);
      check(iabs(int'(yo) - ey) <= 8, "R7", "K*A*sin", int'(yo), ey);

      // R7: rotation by a negative angle near the input limit
      run_full(1'b0, 6000, 0, -15000);
      ex = $rtoi(kg * 6000.0 * $cos(-15000.0 * pi_r / 32768.0));
      ey = $rtoi(kg * 6000.0 * $sin(-15000.0 * pi_r / 32768.0));
      check(iabs(int'(xo) - ex) <= 8, "R7", "K*A*cos neg", int'(xo), ex);
      check(iabs(int'(yo) - ey) <= 8, "R7", "K*A*sin neg", int'(yo), ey);

      // R8: vectoring of (6000, 8000) and of a vector below the axis
      run_full(1'b1, 6000, 8000, 0);
      ex = $rtoi(kg * 10000.0);
      ez = $rtoi($atan2(8000.0, 6000.0) * 32768.0 / pi_r);
      check(iabs(int'(xo) - ex) <= 8, "R8", "magnitude", int'(xo), ex);
      check(iabs(int'(zo) - ez) <= 8, "R8", "arctangent", int'(zo), ez);
      check(iabs(int'(yo)) <= 8, "R5", "y driven to zero", int'(yo), 0);
      run_full(1'b1, 7000, -3000, 0);
      ez = $rtoi($atan2(-3000.0, 7000.0) * 32768.0 / pi_r);
      check(iabs(int'(zo) - ez) <= 8, "R8", "negative arctangent", int'(zo), ez);

      // R10: results held while idle
      xsave = int'(xo); ysave = int'(yo); zsave = int'(zo);
      repeat (7) @(negedge clk);
      check(int'(xo) == xsave && int'(yo) == ysave && int'(zo) == zsave,
            "R10", "hold after done", int'(xo), xsave);
      check(done == 1'b0, "R3", "done cleared while idle", int'(done), 0);

      // R9: reload in the middle of a run
      start(1'b0, 5000, 1000, 3000);
      repeat (5) @(negedge clk);
      run_full(1'b1, 4000, 2000, 0);
      ez = $rtoi($atan2(2000.0, 4000.0) * 32768.0 / pi_r);
      check(iabs(int'(zo) - ez) <= 8, "R9", "restarted run result", int'(zo), ez);
      @(negedge clk);
      check(done == 1'b0, "R9", "no second done", int'(done), 0);

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule